// File: doc/BRIEF.md
# SMBus Host Controller Register Front End

This block is the byte-wide register port that software uses to drive a PC-style SMBus host controller. A small offset space is decoded into a status register, a control register, command and target-address registers, two data bytes, and a block-data window. Behind the window sits a 32-byte buffer that a single auto-incrementing index walks through. Writing the control register with its start bit set marks the host busy and sends a one-cycle start pulse to an external protocol sequencer. The sequencer sees the command, the target, the protocol selection and the data bytes, and it can read the buffer through a side port.

When the sequencer finishes, it raises a done strobe and an error flag. In that same cycle it may return a first and a second data byte and load block bytes into the buffer. The front end clears busy and posts either a success pair (byte done and interrupt) or a device error. Software acknowledges status by writing ones to the bits it wants cleared. An interrupt line is driven while the interrupt status bit is set and the enable bit of the control register is on.

Top module: `smbh_regif`

## Requirements
- R1: Offsets 0x03 (command), 0x04 (target address), 0x05 (data byte 0) and 0x06 (data byte 1) read back the full 8-bit value last written. The command register drives `seq_cmd`. Address bit 0 drives `seq_rnw` and address bits 7:1 drive `seq_target`. Every offset other than 0x00 and 0x02..0x07 reads as 0x00, and writes to those offsets change nothing.
- R2: After reset, the status register reads 0x00, the control register reads 0x00, `bus_rdata` is 0, and `irq` and `seq_start` are low.
- R3: A write to status offset 0x00 clears each status bit whose written bit is 1 and leaves the other bits unchanged. Status bit positions are: 0 busy, 1 interrupt, 2 device error, 3 bus error, 4 failed, 5 alert, 6 in-use, 7 byte done.
- R4: A write to control offset 0x02 stores the value. If bit 6 of the written value is 1, status bit 0 (busy) is set and `seq_start` is high for the cycle after the write. Control bits 4:2 appear on `seq_proto`.
- R5: A read of the control register returns only bits 4:0 of the stored value, and it sets the block index to 0.
- R6: Each access to offset 0x07 reads or writes the buffer entry at the block index and then advances the index. After entry 31 the index returns to 0. `seq_rd_data` shows the entry selected by `seq_rd_idx`.
- R7: A write to the status register sets the block index to 0.
- R8: A done strobe with the error flag low clears busy and sets byte done (bit 7) and interrupt (bit 1).
- R9: A done strobe with the error flag high clears busy and sets device error (bit 2).
- R10: On done, data bytes whose write enables are set are stored into data byte 0 and data byte 1. A sequencer block write stores `seq_blk_wdata` at `seq_blk_idx` and does not move the block index.
- R11: `irq` is high exactly when status bit 1 is 1 and control bit 0 is 1.
- R12: Read data is registered. It appears on `bus_rdata` in the cycle after the accepted read and is held until the next read.
- R13: In one cycle, bits set by done take priority over a write-one clear of the same bits. A start write in the same cycle as done leaves busy set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bus_valid | input | 1 | Access strobe |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| irq | output | 1 | Interrupt request |
| seq_start | output | 1 | One-cycle start pulse to the sequencer |
| seq_proto | output | 3 | Protocol selection (control bits 4:2) |
| seq_rnw | output | 1 | Read/not-write (address bit 0) |
| seq_target | output | 7 | Target address (address bits 7:1) |
| seq_cmd | output | 8 | Command byte |
| seq_data0 | output | 8 | Data byte 0 |
| seq_data1 | output | 8 | Data byte 1 |
| seq_rd_idx | input | $clog2(BLK_DEPTH) | Buffer read index for the sequencer |
| seq_rd_data | output | 8 | Buffer entry at `seq_rd_idx` |
| seq_done | input | 1 | Transaction finished |
| seq_err | input | 1 | Finished with error (qualified by `seq_done`) |
| seq_d0_we | input | 1 | Store `seq_d0` into data byte 0 on done |
| seq_d0 | input | 8 | Returned data byte 0 |
| seq_d1_we | input | 1 | Store `seq_d1` into data byte 1 on done |
| seq_d1 | input | 8 | Returned data byte 1 |
| seq_blk_we | input | 1 | Buffer write from the sequencer |
| seq_blk_idx | input | $clog2(BLK_DEPTH) | Buffer write index from the sequencer |
| seq_blk_wdata | input | 8 | Buffer write data from the sequencer |

## Verification
Every one of the 256 byte values is written to each plain data register and read back, which shows that no bit is lost in the decode or the storage. All 64 offsets are then swept, so that unmapped holes reading zero can be told apart from aliases onto real registers. Every control value with the start bit clear is tried to separate the stored value from the 5-bit readback and from the protocol field. A 40-byte run through the block window shows the wrap after entry 31, as opposed to a saturating or free-running index. Completion is driven alone, together with a write-one clear, and together with a start write, which separates the success, error and same-cycle priority outcomes.

// File: rtl/smbh_pkg.sv
package smbh_pkg;

  // register offsets (decoded by software drivers, so fixed)
  localparam logic [7:0] OFS_STAT = 8'h00;
  localparam logic [7:0] OFS_CTL  = 8'h02;
  localparam logic [7:0] OFS_CMD  = 8'h03;
  localparam logic [7:0] OFS_TGT  = 8'h04;
  localparam logic [7:0] OFS_D0   = 8'h05;
  localparam logic [7:0] OFS_D1   = 8'h06;
  localparam logic [7:0] OFS_BLK  = 8'h07;

  // status bit positions
  localparam int ST_BUSY   = 0;
  localparam int ST_INTR   = 1;
  localparam int ST_DEVERR = 2;
  localparam int ST_BUSERR = 3;
  localparam int ST_FAIL   = 4;
  localparam int ST_ALERT  = 5;
  localparam int ST_INUSE  = 6;
  localparam int ST_BDONE  = 7;

  // control bit positions
  localparam int CTL_IEN   = 0;
  localparam int CTL_START = 6;
  localparam int CTL_KEEP  = 5;   // bits held in the control register

  // write-one-to-clear update
  function automatic logic [7:0] w1c_apply(input logic [7:0] cur, input logic [7:0] mask);
    return cur & ~mask;
  endfunction

  // wrapping increment of the block index
  function automatic int idx_advance(input int cur, input int depth);
    return (cur >= depth - 1) ? 0 : cur + 1;
  endfunction

  // status bits posted by a completion
  function automatic logic [7:0] done_bits(input logic err);
    logic [7:0] b;
    b = 8'h00;
    if (err) b[ST_DEVERR] = 1'b1;
    else begin
      b[ST_BDONE] = 1'b1;
      b[ST_INTR]  = 1'b1;
    end
    return b;
  endfunction

endpackage

// File: rtl/smbh_status.sv
module smbh_status
  import smbh_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       w1c_evt,
  input  logic [7:0] w1c_mask,
  input  logic       start_evt,
  input  logic       done_evt,
  input  logic       done_err,
  output logic [7:0] stat_q
);

  logic [7:0] stat_d;

  always_comb begin
    stat_d = stat_q;
    if (w1c_evt) stat_d = w1c_apply(stat_d, w1c_mask);
    if (done_evt) begin
      stat_d[ST_BUSY] = 1'b0;
      stat_d = stat_d | done_bits(done_err);
    end
    if (start_evt) stat_d[ST_BUSY] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat_q <= 8'h00;
    else        stat_q <= stat_d;
  end

  // R8
  done_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_evt && !done_err |=> stat_q[ST_BDONE] && stat_q[ST_INTR]);

  // R9
  done_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_evt && done_err |=> stat_q[ST_DEVERR]);

  // R4
  start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> stat_q[ST_BUSY]);

  // R3
  w1c_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    w1c_evt && !done_evt && !start_evt |=> (stat_q & $past(w1c_mask)) == 8'h00);

endmodule

// File: rtl/smbh_blkbuf.sv
module smbh_blkbuf
  import smbh_pkg::*;
#(
  parameter int DEPTH = 32,
  localparam int IW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          host_acc,
  input  logic          host_we,
  input  logic [7:0]    host_wdata,
  input  logic          idx_clr,
  output logic [7:0]    host_rdata,
  input  logic          seq_we,
  input  logic [IW-1:0] seq_widx,
  input  logic [7:0]    seq_wdata,
  input  logic [IW-1:0] seq_ridx,
  output logic [7:0]    seq_rdata
);

  logic [7:0]    mem [DEPTH];
  logic [IW-1:0] idx_q;
  logic [IW-1:0] idx_nxt;
  logic          idx_wrap;

  assign idx_nxt  = IW'(idx_advance(int'(idx_q), DEPTH));
  assign idx_wrap = host_acc && (int'(idx_q) == DEPTH - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        idx_q <= '0;
    else if (idx_clr)  idx_q <= '0;
    else if (host_acc) idx_q <= idx_nxt;
  end

  // one register per entry; the sequencer port wins a shared entry
  for (genvar e = 0; e < DEPTH; e++) begin : g_ent
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mem[e] <= 8'h00;
      else if (seq_we && (int'(seq_widx) == e)) mem[e] <= seq_wdata;
      else if (host_acc && host_we && (int'(idx_q) == e)) mem[e] <= host_wdata;
    end
  end

  assign host_rdata = mem[idx_q];
  assign seq_rdata  = mem[seq_ridx];

  // R6
  idx_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    idx_wrap && !idx_clr |=> idx_q == '0);

  // R6
  idx_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    host_acc && !idx_clr && !idx_wrap |=> idx_q == $past(idx_q) + 1'b1);

  // R5 R7
  idx_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    idx_clr |=> idx_q == '0);

endmodule

// File: rtl/smbh_cfgregs.sv
module smbh_cfgregs
  import smbh_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic [7:0]          wdata,
  input  logic                wr_ctl,
  input  logic                wr_cmd,
  input  logic                wr_tgt,
  input  logic                wr_d0,
  input  logic                wr_d1,
  input  logic                seq_d0_we,
  input  logic [7:0]          seq_d0,
  input  logic                seq_d1_we,
  input  logic [7:0]          seq_d1,
  output logic [CTL_KEEP-1:0] ctl_q,
  output logic [7:0]          cmd_q,
  output logic [7:0]          tgt_q,
  output logic [7:0]          d0_q,
  output logic [7:0]          d1_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q <= '0;
      cmd_q <= 8'h00;
      tgt_q <= 8'h00;
    end else begin
      if (wr_ctl) ctl_q <= wdata[CTL_KEEP-1:0];
      if (wr_cmd) cmd_q <= wdata;
      if (wr_tgt) tgt_q <= wdata;
    end
  end

  // returned data overrides a host write in the same cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      d0_q <= 8'h00;
      d1_q <= 8'h00;
    end else begin
      if (seq_d0_we)  d0_q <= seq_d0;
      else if (wr_d0) d0_q <= wdata;
      if (seq_d1_we)  d1_q <= seq_d1;
      else if (wr_d1) d1_q <= wdata;
    end
  end

  // R10
  ret_d0_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seq_d0_we |=> d0_q == $past(seq_d0));

  // R10
  ret_d1_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seq_d1_we |=> d1_q == $past(seq_d1));

endmodule

// File: rtl/smbh_regif.sv
module smbh_regif
  import smbh_pkg::*;
#(
  parameter int ADDR_W    = 6,
  parameter int BLK_DEPTH = 32
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         bus_valid,
  input  logic                         bus_write,
  input  logic [ADDR_W-1:0]            bus_addr,
  input  logic [7:0]                   bus_wdata,
  output logic [7:0]                   bus_rdata,
  output logic                         irq,
  output logic                         seq_start,
  output logic [2:0]                   seq_proto,
  output logic                         seq_rnw,
  output logic [6:0]                   seq_target,
  output logic [7:0]                   seq_cmd,
  output logic [7:0]                   seq_data0,
  output logic [7:0]                   seq_data1,
  input  logic [$clog2(BLK_DEPTH)-1:0] seq_rd_idx,
  output logic [7:0]                   seq_rd_data,
  input  logic                         seq_done,
  input  logic                         seq_err,
  input  logic                         seq_d0_we,
  input  logic [7:0]                   seq_d0,
  input  logic                         seq_d1_we,
  input  logic [7:0]                   seq_d1,
  input  logic                         seq_blk_we,
  input  logic [$clog2(BLK_DEPTH)-1:0] seq_blk_idx,
  input  logic [7:0]                   seq_blk_wdata
);

  localparam int IW = $clog2(BLK_DEPTH);

  // decoded access events
  logic [7:0] ofs;
  logic wr_evt, rd_evt;
  logic hit_stat, hit_ctl, hit_cmd, hit_tgt, hit_d0, hit_d1, hit_blk;
  logic start_evt, w1c_evt, idx_clr, blk_acc;

  assign ofs      = 8'(bus_addr);
  assign wr_evt   = bus_valid && bus_write;
  assign rd_evt   = bus_valid && !bus_write;
  assign hit_stat = (ofs == OFS_STAT);
  assign hit_ctl  = (ofs == OFS_CTL);
  assign hit_cmd  = (ofs == OFS_CMD);
  assign hit_tgt  = (ofs == OFS_TGT);
  assign hit_d0   = (ofs == OFS_D0);
  assign hit_d1   = (ofs == OFS_D1);
  assign hit_blk  = (ofs == OFS_BLK);

  assign start_evt = wr_evt && hit_ctl && bus_wdata[CTL_START];
  assign w1c_evt   = wr_evt && hit_stat;
  assign idx_clr   = w1c_evt || (rd_evt && hit_ctl);
  assign blk_acc   = bus_valid && hit_blk;

  logic [CTL_KEEP-1:0] ctl_q;
  logic [7:0] cmd_q, tgt_q, d0_q, d1_q, stat_q, blk_rdata;

  smbh_cfgregs u_cfg (
    .clk       (clk),
    .rst_n     (rst_n),
    .wdata     (bus_wdata),
    .wr_ctl    (wr_evt && hit_ctl),
    .wr_cmd    (wr_evt && hit_cmd),
    .wr_tgt    (wr_evt && hit_tgt),
    .wr_d0     (wr_evt && hit_d0),
    .wr_d1     (wr_evt && hit_d1),
    .seq_d0_we (seq_done && seq_d0_we),
    .seq_d0    (seq_d0),
    .seq_d1_we (seq_done && seq_d1_we),
    .seq_d1    (seq_d1),
    .ctl_q     (ctl_q),
    .cmd_q     (cmd_q),
    .tgt_q     (tgt_q),
    .d0_q      (d0_q),
    .d1_q      (d1_q)
  );

  smbh_status u_stat (
    .clk       (clk),
    .rst_n     (rst_n),
    .w1c_evt   (w1c_evt),
    .w1c_mask  (bus_wdata),
    .start_evt (start_evt),
    .done_evt  (seq_done),
    .done_err  (seq_err),
    .stat_q    (stat_q)
  );

  smbh_blkbuf #(.DEPTH(BLK_DEPTH)) u_blk (
    .clk        (clk),
    .rst_n      (rst_n),
    .host_acc   (blk_acc),
    .host_we    (bus_write),
    .host_wdata (bus_wdata),
    .idx_clr    (idx_clr),
    .host_rdata (blk_rdata),
    .seq_we     (seq_blk_we),
    .seq_widx   (seq_blk_idx),
    .seq_wdata  (seq_blk_wdata),
    .seq_ridx   (seq_rd_idx),
    .seq_rdata  (seq_rd_data)
  );

  // read mux and registered read data
  logic [7:0] rd_mux;
  always_comb begin
    rd_mux = 8'h00;
    if (hit_stat) rd_mux = stat_q;
    if (hit_ctl)  rd_mux = 8'(ctl_q);
    if (hit_cmd)  rd_mux = cmd_q;
    if (hit_tgt)  rd_mux = tgt_q;
    if (hit_d0)   rd_mux = d0_q;
    if (hit_d1)   rd_mux = d1_q;
    if (hit_blk)  rd_mux = blk_rdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_rdata <= 8'h00;
      seq_start <= 1'b0;
    end else begin
      seq_start <= start_evt;
      if (rd_evt) bus_rdata <= rd_mux;
    end
  end

  assign irq        = stat_q[ST_INTR] && ctl_q[CTL_IEN];
  assign seq_proto  = ctl_q[4:2];
  assign seq_rnw    = tgt_q[0];
  assign seq_target = tgt_q[7:1];
  assign seq_cmd    = cmd_q;
  assign seq_data0  = d0_q;
  assign seq_data1  = d1_q;

  // R4
  start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> seq_start);

  // R12
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_evt |=> $stable(bus_rdata));

  // R13
  busy_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt && seq_done |=> stat_q[ST_BUSY]);

endmodule

// File: tb/tb_smbh_regif.sv
module tb_smbh_regif;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 32;
  localparam int IW = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_valid = 0, bus_write = 0;
  logic [5:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic irq, seq_start, seq_rnw;
  logic [2:0] seq_proto;
  logic [6:0] seq_target;
  logic [7:0] seq_cmd, seq_data0, seq_data1, seq_rd_data;
  logic [IW-1:0] seq_rd_idx = '0;
  logic seq_done = 0, seq_err = 0, seq_d0_we = 0, seq_d1_we = 0, seq_blk_we = 0;
  logic [7:0] seq_d0 = '0, seq_d1 = '0, seq_blk_wdata = '0;
  logic [IW-1:0] seq_blk_idx = '0;

  int nchk = 0, nfail = 0;
  logic [7:0] model [DEPTH];
  logic [7:0] rv;

  always #(CLK_PERIOD/2) clk = ~clk;

  smbh_regif #(.ADDR_W(6), .BLK_DEPTH(DEPTH)) dut (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq),
    .seq_start(seq_start), .seq_proto(seq_proto), .seq_rnw(seq_rnw),
    .seq_target(seq_target), .seq_cmd(seq_cmd), .seq_data0(seq_data0),
    .seq_data1(seq_data1), .seq_rd_idx(seq_rd_idx), .seq_rd_data(seq_rd_data),
    .seq_done(seq_done), .seq_err(seq_err), .seq_d0_we(seq_d0_we), .seq_d0(seq_d0),
    .seq_d1_we(seq_d1_we), .seq_d1(seq_d1), .seq_blk_we(seq_blk_we),
    .seq_blk_idx(seq_blk_idx), .seq_blk_wdata(seq_blk_wdata)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  // one bus cycle, optionally with a completion in the same cycle
  task automatic cyc(input logic v, input logic w, input logic [5:0] a, input logic [7:0] d,
                     input logic dn, input logic er);
    bus_valid = v; bus_write = w; bus_addr = a; bus_wdata = d;
    seq_done = dn; seq_err = er;
    @(posedge clk);
    @(negedge clk);
    bus_valid = 0; bus_write = 0; seq_done = 0; seq_err = 0;
    seq_d0_we = 0; seq_d1_we = 0; seq_blk_we = 0;
  endtask

  task automatic wr(input logic [5:0] a, input logic [7:0] d);
    cyc(1, 1, a, d, 0, 0);
  endtask

  task automatic rd(input logic [5:0] a, output logic [7:0] d);
    cyc(1, 0, a, 8'h00, 0, 0);
    d = bus_rdata;
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: actual %0d expected 0", 1);
    finish_run();
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) model[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 reset state
    chk("R2 rdata", bus_rdata, 8'h00);
    chk("R2 irq", {7'd0, irq}, 8'h00);
    chk("R2 start", {7'd0, seq_start}, 8'h00);
    rd(6'h00, rv); chk("R2 status", rv, 8'h00);
    rd(6'h02, rv); chk("R2 control", rv, 8'h00);

    // R1 full-value sweep of plain registers
    for (int v = 0; v < 256; v++) begin
      wr(6'h03, 8'(v)); rd(6'h03, rv); chk("R1 cmd", rv, 8'(v)); chk("R1 seq_cmd", seq_cmd, 8'(v));
      wr(6'h04, 8'(v)); rd(6'h04, rv); chk("R1 tgt", rv, 8'(v));
      chk("R1 target", {1'b0, seq_target}, 8'(v >> 1)); chk("R1 rnw", {7'd0, seq_rnw}, 8'(v & 1));
      wr(6'h05, 8'(v)); rd(6'h05, rv); chk("R1 d0", rv, 8'(v)); chk("R1 seq_d0", seq_data0, 8'(v));
      wr(6'h06, 8'(v)); rd(6'h06, rv); chk("R1 d1", rv, 8'(v)); chk("R1 seq_d1", seq_data1, 8'(v));
    end

    // R1 unmapped offsets
    wr(6'h03, 8'h11);
    for (int o = 0; o < 64; o++) begin
      if (o == 1 || o > 7) begin
        wr(6'(o), 8'hFF);
        rd(6'(o), rv); chk("R1 unmapped", rv, 8'h00);
      end
    end
    rd(6'h03, rv); chk("R1 unmapped write ignored", rv, 8'h11);
    rd(6'h00, rv); chk("R1 unmapped status", rv, 8'h00);

    // R4 R5 control values with start clear
    for (int v = 0; v < 256; v++) begin
      if (((v >> 6) & 1) == 0) begin
        wr(6'h02, 8'(v));
        chk("R4 no start", {7'd0, seq_start}, 8'h00);
        chk("R4 proto", {5'd0, seq_proto}, 8'((v >> 2) & 7));
        rd(6'h02, rv); chk("R5 ctl readback", rv, 8'(v & 8'h1F));
      end
    end
    wr(6'h02, 8'h00);

    // R6 R7 block buffer with wrap
    wr(6'h00, 8'h00);
    for (int i = 0; i < 40; i++) begin
      wr(6'h07, 8'(i * 7 + 3));
      model[i % DEPTH] = 8'(i * 7 + 3);
    end
    rd(6'h02, rv);
    for (int i = 0; i < 40; i++) begin
      rd(6'h07, rv); chk("R6 block wrap", rv, model[i % DEPTH]);
    end
    for (int i = 0; i < DEPTH; i += 9) begin
      seq_rd_idx = IW'(i); #1;
      chk("R6 seq read port", seq_rd_data, model[i]);
    end
    rd(6'h07, rv); rd(6'h07, rv); rd(6'h07, rv);
    wr(6'h00, 8'h00);
    rd(6'h07, rv); chk("R7 index reset", rv, model[0]);
    rd(6'h07, rv); rd(6'h02, rv);
    rd(6'h07, rv); chk("R5 index reset", rv, model[0]);

    // R4 start then R8 R10 success with returned data
    wr(6'h02, 8'h49);
    chk("R4 start pulse", {7'd0, seq_start}, 8'h01);
    chk("R4 proto", {5'd0, seq_proto}, 8'h02);
    rd(6'h00, rv); chk("R4 busy", rv, 8'h01);
    chk("R4 pulse width", {7'd0, seq_start}, 8'h00);
    seq_d0_we = 1; seq_d0 = 8'h5C; seq_d1_we = 1; seq_d1 = 8'h3E;
    seq_blk_we = 1; seq_blk_idx = 5'd4; seq_blk_wdata = 8'hEE;
    cyc(0, 0, 6'h00, 8'h00, 1, 0);
    model[4] = 8'hEE;
    rd(6'h00, rv); chk("R8 success bits", rv, 8'h82);
    chk("R11 irq on", {7'd0, irq}, 8'h01);
    rd(6'h05, rv); chk("R10 d0", rv, 8'h5C);
    rd(6'h06, rv); chk("R10 d1", rv, 8'h3E);
    rd(6'h02, rv); chk("R5 ctl low bits", rv, 8'h09);
    for (int i = 0; i < 5; i++) begin
      rd(6'h07, rv); chk("R10 block", rv, model[i]);
    end

    // R3 write-one clear
    wr(6'h00, 8'h02);
    rd(6'h00, rv); chk("R3 clear intr", rv, 8'h80);
    chk("R11 irq off", {7'd0, irq}, 8'h00);
    wr(6'h00, 8'h7D);
    rd(6'h00, rv); chk("R3 zero bits kept", rv, 8'h80);
    wr(6'h00, 8'h80);
    rd(6'h00, rv); chk("R3 clear bdone", rv, 8'h00);

    // R9 error then success accumulates
    wr(6'h02, 8'h40);
    cyc(0, 0, 6'h00, 8'h00, 1, 1);
    rd(6'h00, rv); chk("R9 dev err", rv, 8'h04);
    wr(6'h02, 8'h40);
    cyc(0, 0, 6'h00, 8'h00, 1, 0);
    rd(6'h00, rv); chk("R9 accumulate", rv, 8'h86);
    chk("R11 irq disabled", {7'd0, irq}, 8'h00);
    wr(6'h00, 8'hFF);
    rd(6'h00, rv); chk("R3 clear all", rv, 8'h00);

    // R13 same-cycle priorities
    wr(6'h02, 8'h40);
    cyc(1, 1, 6'h00, 8'hFF, 1, 0);
    rd(6'h00, rv); chk("R13 done beats clear", rv, 8'h82);
    wr(6'h00, 8'hFF);
    cyc(1, 1, 6'h02, 8'h40, 1, 0);
    rd(6'h00, rv); chk("R13 start keeps busy", rv, 8'h83);
    wr(6'h00, 8'hFF);

    // R11 enable and interrupt combinations
    for (int en = 0; en < 2; en++) begin
      for (int it = 0; it < 2; it++) begin
        wr(6'h00, 8'hFF);
        wr(6'h02, 8'(en));
        if (it == 1) begin
          wr(6'h02, 8'(8'h40 | en));
          cyc(0, 0, 6'h00, 8'h00, 1, 0);
        end
        chk("R11 irq combo", {7'd0, irq}, 8'(en & it));
      end
    end

    // R12 read data held across non-read cycles
    rd(6'h03, rv);
    wr(6'h03, 8'h99);
    cyc(0, 0, 6'h00, 8'h00, 0, 0);
    chk("R12 hold", bus_rdata, rv);

    finish_run();
  end
endmodule